// File: doc/BRIEF.md
# Multithread Core Run-Control Register Unit

This block gives a management agent control over the hardware threads of one processor core, through a 64-bit register bus that only accepts full 8-byte aligned accesses. A write to the control register is split into one 8-bit lane per thread. Each lane can command stop, start, soft reset or clear-maintenance. The unit turns each command into a one-clock pulse on a per-thread output and keeps a per-thread stopped flag. Two read-only registers report which threads are halted and which are stopped. A sticky flag records any control write that sets bits the unit does not implement.

Bits are numbered most-significant first. Bit n of the register therefore sits at bus data bit 63-n. The register index is the byte address shifted right by three. A thread-count parameter from 1 to 4 selects how many lanes are live.

Top module: `thread_runctl`

## Requirements
- R1: An access is valid only when `req_bytes` is 8 and address bits 2:0 are zero. An invalid write changes nothing. An invalid read returns zero. Every read answers with `rsp_valid` and `rsp_rdata` exactly one clock later.
- R2: A valid write to index 0x449 with bus bit 56-8i set (MSB-first bit 7+8i, stop) pulses `stop_pulse[i]` and sets `stopped[i]`.
- R3: A valid write to index 0x449 with bus bit 57-8i set (start) or bus bit 60-8i set (clear maintenance) pulses `start_pulse[i]` and clears `stopped[i]`.
- R4: When stop and start arrive in the same write, both pulses fire and the thread is left running (`stopped[i]`=0).
- R5: Bus bit 59-8i (soft reset) pulses `sreset_pulse[i]` and leaves `stopped[i]` unchanged.
- R6: A read of index 0x412 returns bus bit 7-i equal to `halted_in[i]` and bus bit 1 equal to `one_lpar_in`. All other bits read zero.
- R7: A read of index 0x454 returns bus bits 63-8i and 62-8i both set for each stopped thread i. All other bits read zero.
- R8: Reads of index 0x413, of the write-only index 0x449 and of any unimplemented index return zero.
- R9: A valid control write with any bit set outside the command bits of the live lanes sets `unsup_err`. The flag stays set until `err_clear` is asserted. A new unsupported write in the same cycle as `err_clear` leaves it set.
- R10: With fewer than four threads, the command bits of the unused lanes count as unsupported and cause no pulse.
- R11: Command pulses appear in the cycle after the accepting edge and last one clock. After reset all pulses, flags and `rsp_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, bit 63 = MSB-first bit 0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| halted_in | input | NUM_THREADS | Per-thread halted status |
| one_lpar_in | input | 1 | One-partition-per-core configuration |
| err_clear | input | 1 | Clears the unsupported-bit flag |
| stop_pulse | output | NUM_THREADS | One-clock stop command |
| start_pulse | output | NUM_THREADS | One-clock start command (start or clear maintenance) |
| sreset_pulse | output | NUM_THREADS | One-clock soft-reset command |
| stopped | output | NUM_THREADS | Per-thread stopped flag |
| unsup_err | output | 1 | Sticky unsupported-bit flag |

## Verification
The bench targets the lane bit mapping under MSB-first numbering. A design that reverses the numbering, or shifts lanes by one bit, drives the wrong thread's pulse or fails to set the RAS pattern. It writes stop and start together, because a design that applies stop last leaves that thread stopped. It checks that soft reset leaves a stopped thread stopped, and that clear maintenance resumes one. It sends a 4-byte access and expects nothing to change. It checks that an error set in the same cycle as a clear survives. A two-thread instance confirms that upper-lane commands raise the error and pulse nothing.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
  localparam int WORD_W      = 64;
  localparam int LANE_W      = 8;
  localparam int MAX_THREADS = 4;

  localparam int IDX_STATE = 'h412;
  localparam int IDX_INFO  = 'h413;
  localparam int IDX_CTRL  = 'h449;
  localparam int IDX_RAS   = 'h454;

  // MSB-first bit offsets of commands inside a lane
  localparam int CMD_STOP   = 7;
  localparam int CMD_START  = 6;
  localparam int CMD_SRESET = 4;
  localparam int CMD_CLRM   = 3;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_STATE = 2'd1,
    SEL_RAS   = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  // MSB-first bit number to bus vector position
  function automatic int be_pos(input int n);
    return WORD_W - 1 - n;
  endfunction
endpackage

// File: rtl/rc_decode.sv
module rc_decode
  import runctl_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  output reg_sel_e          sel,
  output logic              wr_ok,
  output logic              rd_any
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             shape_ok;

  assign idx      = req_addr[ADDR_W-1:3];
  assign shape_ok = (req_bytes == 4'd8) && (req_addr[2:0] == 3'b000);

  always_comb begin
    sel = SEL_NONE;
    if (shape_ok) begin
      if (idx == IDX_W'(IDX_STATE))     sel = SEL_STATE;
      else if (idx == IDX_W'(IDX_RAS))  sel = SEL_RAS;
      else if (idx == IDX_W'(IDX_CTRL)) sel = SEL_CTRL;
    end
  end

  assign wr_ok  = req_valid && req_write && (sel == SEL_CTRL);
  assign rd_any = req_valid && !req_write;
endmodule

// File: rtl/rc_lane.sv
module rc_lane
  import runctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en,
  input  logic [LANE_W-1:0] lane_bits,
  output logic              stop_o,
  output logic              start_o,
  output logic              sreset_o,
  output logic              stopped_o
);
  // lane_bits[LANE_W-1] is MSB-first lane bit 0
  logic c_stop, c_start, c_sreset, c_clrm;

  assign c_stop   = lane_bits[LANE_W-1-CMD_STOP];
  assign c_start  = lane_bits[LANE_W-1-CMD_START];
  assign c_sreset = lane_bits[LANE_W-1-CMD_SRESET];
  assign c_clrm   = lane_bits[LANE_W-1-CMD_CLRM];

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_o    <= 1'b0;
      start_o   <= 1'b0;
      sreset_o  <= 1'b0;
      stopped_o <= 1'b0;
    end else begin
      stop_o   <= cmd_en && c_stop;
      start_o  <= cmd_en && (c_start || c_clrm);
      sreset_o <= cmd_en && c_sreset;
      if (cmd_en) begin
        if (c_start || c_clrm) stopped_o <= 1'b0;
        else if (c_stop)       stopped_o <= 1'b1;
      end
    end
  end

  assert_stop_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (stop_o && !start_o) |-> stopped_o);
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !stopped_o);
  assert_sreset_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (sreset_o && !stop_o && !start_o) |-> $stable(stopped_o));
endmodule

// File: rtl/rc_readback.sv
module rc_readback
  import runctl_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  reg_sel_e               sel,
  input  logic [NUM_THREADS-1:0] halted_in,
  input  logic                   one_lpar_in,
  input  logic [NUM_THREADS-1:0] stopped_in,
  output logic                   rsp_valid,
  output logic [WORD_W-1:0]      rsp_rdata
);
  logic [WORD_W-1:0] state_w, ras_w, next_w;

  always_comb begin
    state_w = '0;
    ras_w   = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      state_w[be_pos(56 + i)]          = halted_in[i];
      ras_w[be_pos(LANE_W * i)]        = stopped_in[i];
      ras_w[be_pos(LANE_W * i + 1)]    = stopped_in[i];
    end
    state_w[be_pos(62)] = one_lpar_in;
  end

  always_comb begin
    case (sel)
      SEL_STATE: next_w = state_w;
      SEL_RAS:   next_w = ras_w;
      default:   next_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? next_w : '0;
    end
  end

  assert_rsp_follows_read_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_en));
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_rdata == '0));
endmodule

// File: rtl/thread_runctl.sv
module thread_runctl
  import runctl_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [3:0]             req_bytes,
  input  logic [63:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [63:0]            rsp_rdata,
  input  logic [NUM_THREADS-1:0] halted_in,
  input  logic                   one_lpar_in,
  input  logic                   err_clear,
  output logic [NUM_THREADS-1:0] stop_pulse,
  output logic [NUM_THREADS-1:0] start_pulse,
  output logic [NUM_THREADS-1:0] sreset_pulse,
  output logic [NUM_THREADS-1:0] stopped,
  output logic                   unsup_err
);
  localparam int CMD_CNT = 4;

  reg_sel_e          sel;
  logic              wr_ok, rd_any;
  logic [WORD_W-1:0] legal_mask;
  logic              bad_bits;

  rc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_bytes (req_bytes),
    .sel       (sel),
    .wr_ok     (wr_ok),
    .rd_any    (rd_any)
  );

  generate
    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_lane
      rc_lane u_lane (
        .clk       (clk),
        .rst       (rst),
        .cmd_en    (wr_ok),
        .lane_bits (req_wdata[WORD_W-1-LANE_W*i -: LANE_W]),
        .stop_o    (stop_pulse[i]),
        .start_o   (start_pulse[i]),
        .sreset_o  (sreset_pulse[i]),
        .stopped_o (stopped[i])
      );
    end
  endgenerate

  always_comb begin
    int cmd_bits [CMD_CNT];
    cmd_bits = '{CMD_STOP, CMD_START, CMD_SRESET, CMD_CLRM};
    legal_mask = '0;
    for (int i = 0; i < NUM_THREADS; i++)
      for (int k = 0; k < CMD_CNT; k++)
        legal_mask[be_pos(LANE_W * i + cmd_bits[k])] = 1'b1;
  end

  assign bad_bits = |(req_wdata & ~legal_mask);

  always_ff @(posedge clk) begin
    if (rst)                      unsup_err <= 1'b0;
    else if (wr_ok && bad_bits)   unsup_err <= 1'b1;
    else if (err_clear)           unsup_err <= 1'b0;
  end

  rc_readback #(.NUM_THREADS(NUM_THREADS)) u_rb (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_any),
    .sel         (sel),
    .halted_in   (halted_in),
    .one_lpar_in (one_lpar_in),
    .stopped_in  (stopped),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (unsup_err && !err_clear) |=> unsup_err);
  assert_err_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_bytes == 4'd8 && req_addr[2:0] == 3'b000 &&
     req_addr[ADDR_W-1:3] == (ADDR_W-3)'(IDX_CTRL) && bad_bits) |=> unsup_err);
  assert_pulse_needs_write_R11: assert property (@(posedge clk) disable iff (rst)
    (|{stop_pulse, start_pulse, sreset_pulse}) |-> $past(req_valid && req_write));
  assert_no_pulse_on_read_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(|{stop_pulse, start_pulse, sreset_pulse}));
endmodule

// File: tb/sim_thread_runctl.sv
module sim_thread_runctl;
  localparam int AW = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v0 = 1'b0, v1 = 1'b0;
  logic        wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]  bytes = 4'd8;
  logic [63:0] wdata = '0;
  logic        eclr = 1'b0;
  logic [3:0]  halted = 4'b0101;
  logic        lpar = 1'b1;

  logic        rv0, rv1;
  logic [63:0] rd0, rd1;
  logic [3:0]  sp0, st0, sr0, sd0;
  logic [1:0]  sp1, st1, sr1, sd1;
  logic        er0, er1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  thread_runctl #(.NUM_THREADS(4), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_valid(v0), .req_write(wr), .req_addr(addr),
    .req_bytes(bytes), .req_wdata(wdata), .rsp_valid(rv0), .rsp_rdata(rd0),
    .halted_in(halted), .one_lpar_in(lpar), .err_clear(eclr),
    .stop_pulse(sp0), .start_pulse(st0), .sreset_pulse(sr0),
    .stopped(sd0), .unsup_err(er0));

  thread_runctl #(.NUM_THREADS(2), .ADDR_W(AW)) u1 (
    .clk(clk), .rst(rst), .req_valid(v1), .req_write(wr), .req_addr(addr),
    .req_bytes(bytes), .req_wdata(wdata), .rsp_valid(rv1), .rsp_rdata(rd1),
    .halted_in(halted[1:0]), .one_lpar_in(lpar), .err_clear(eclr),
    .stop_pulse(sp1), .start_pulse(st1), .sreset_pulse(sr1),
    .stopped(sd1), .unsup_err(er1));

  function automatic logic [63:0] cmdw(input int lane, input int k);
    logic [63:0] w = '0;
    w[63 - (8 * lane + k)] = 1'b1;
    return w;
  endfunction

  function automatic logic [63:0] ras(input logic [3:0] m);
    logic [63:0] w = '0;
    for (int i = 0; i < 4; i++)
      if (m[i]) begin w[63 - 8 * i] = 1'b1; w[62 - 8 * i] = 1'b1; end
    return w;
  endfunction

  typedef struct packed {
    logic        wr;
    logic [11:0] idx;
    logic [3:0]  nb;
    logic [63:0] data;
    logic [3:0]  e_stop;
    logic [3:0]  e_start;
    logic [3:0]  e_sreset;
    logic [63:0] e_rd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h412, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'h0000_0000_0000_00A2},
    '{1'b0, 12'h454, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'd0},
    '{1'b1, 12'h449, 4'd8, cmdw(0,7) | cmdw(2,7), 4'b0101, 4'b0000, 4'b0000, 64'd0},
    '{1'b0, 12'h454, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, ras(4'b0101)},
    '{1'b1, 12'h449, 4'd8, cmdw(0,6), 4'b0000, 4'b0001, 4'b0000, 64'd0},
    '{1'b0, 12'h454, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, ras(4'b0100)},
    '{1'b1, 12'h449, 4'd8, cmdw(2,3), 4'b0000, 4'b0100, 4'b0000, 64'd0},
    '{1'b0, 12'h454, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'd0},
    '{1'b1, 12'h449, 4'd8, cmdw(1,7) | cmdw(1,6), 4'b0010, 4'b0010, 4'b0000, 64'd0},
    '{1'b0, 12'h454, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'd0},
    '{1'b1, 12'h449, 4'd8, cmdw(3,7), 4'b1000, 4'b0000, 4'b0000, 64'd0},
    '{1'b1, 12'h449, 4'd8, cmdw(3,4), 4'b0000, 4'b0000, 4'b1000, 64'd0},
    '{1'b0, 12'h454, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, ras(4'b1000)},
    '{1'b0, 12'h413, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'd0},
    '{1'b0, 12'h449, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'd0},
    '{1'b0, 12'h123, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'd0},
    '{1'b1, 12'h449, 4'd4, cmdw(1,7), 4'b0000, 4'b0000, 4'b0000, 64'd0},
    '{1'b0, 12'h454, 4'd8, 64'd0, 4'b0000, 4'b0000, 4'b0000, ras(4'b1000)},
    '{1'b0, 12'h412, 4'd4, 64'd0, 4'b0000, 4'b0000, 4'b0000, 64'd0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge passes, sample at next negedge
  task automatic access(input bit tgt, input bit w, input logic [11:0] idx,
                        input logic [3:0] nb, input logic [63:0] d);
    @(negedge clk);
    wr = w; addr = AW'({idx, 3'b000}); bytes = nb; wdata = d;
    v0 = (tgt == 1'b0); v1 = (tgt == 1'b1);
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check({sp0, st0, sr0, sd0, er0, rv0} == '0, "R11 reset", {sp0, st0, sr0, sd0}, 64'd0);
    check(rd0 == '0, "R11 reset rdata", rd0, 64'd0);

    for (int n = 0; n < NV; n++) begin
      access(1'b0, TBL[n].wr, TBL[n].idx, TBL[n].nb, TBL[n].data);
      check(sp0 == TBL[n].e_stop, "R2 stop pulse", 64'(sp0), 64'(TBL[n].e_stop));
      check(st0 == TBL[n].e_start, "R3 start pulse", 64'(st0), 64'(TBL[n].e_start));
      check(sr0 == TBL[n].e_sreset, "R5 sreset pulse", 64'(sr0), 64'(TBL[n].e_sreset));
      if (!TBL[n].wr) begin
        check(rv0 == 1'b1, "R1 rsp_valid", 64'(rv0), 64'd1);
        check(rd0 == TBL[n].e_rd, "R6 R7 R8 rdata", rd0, TBL[n].e_rd);
      end
    end
    // R4 stop+start left lane 1 running; R5 lane 3 still stopped
    check(sd0 == 4'b1000, "R4 R5 stopped flags", 64'(sd0), 64'h8);
    check(er0 == 1'b0, "R9 no spurious err", 64'(er0), 64'd0);

    // R11 pulse lasts one clock
    access(1'b0, 1'b1, 12'h449, 4'd8, cmdw(0, 7));
    check(sp0 == 4'b0001, "R11 pulse", 64'(sp0), 64'h1);
    @(negedge clk);
    check(sp0 == 4'b0000, "R11 pulse one clock", 64'(sp0), 64'h0);

    // R9 sticky error
    access(1'b0, 1'b1, 12'h449, 4'd8, 64'h8000_0000_0000_0000);
    check(er0 == 1'b1, "R9 err set", 64'(er0), 64'd1);
    access(1'b0, 1'b1, 12'h449, 4'd8, cmdw(0, 6));
    check(er0 == 1'b1, "R9 err sticky", 64'(er0), 64'd1);
    @(negedge clk); eclr = 1'b1;
    @(negedge clk); eclr = 1'b0;
    check(er0 == 1'b0, "R9 err clear", 64'(er0), 64'd0);
    @(negedge clk);
    eclr = 1'b1; wr = 1'b1; addr = AW'({12'h449, 3'b000}); bytes = 4'd8;
    wdata = cmdw(2, 0); v0 = 1'b1;
    @(negedge clk);
    v0 = 1'b0; eclr = 1'b0;
    check(er0 == 1'b1, "R9 set wins over clear", 64'(er0), 64'd1);
    // R1 invalid (misaligned) write causes no pulse
    @(negedge clk);
    wr = 1'b1; addr = AW'({12'h449, 3'b100}); bytes = 4'd8; wdata = cmdw(1, 7); v0 = 1'b1;
    @(negedge clk);
    v0 = 1'b0;
    check(sp0 == 4'b0000 && sd0[1] == 1'b0, "R1 misaligned ignored", 64'(sp0), 64'd0);

    // R10 two-thread instance
    access(1'b1, 1'b1, 12'h449, 4'd8, cmdw(3, 7));
    check(sp1 == 2'b00 && sd1 == 2'b00, "R10 unused lane no pulse", 64'(sp1), 64'd0);
    check(er1 == 1'b1, "R10 unused lane unsupported", 64'(er1), 64'd1);
    access(1'b1, 1'b1, 12'h449, 4'd8, cmdw(1, 7));
    check(sp1 == 2'b10, "R10 live lane pulse", 64'(sp1), 64'h2);
    access(1'b1, 1'b0, 12'h454, 4'd8, 64'd0);
    check(rd1 == ras(4'b0010), "R7 ras two-thread", rd1, ras(4'b0010));
    access(1'b1, 1'b0, 12'h412, 4'd8, 64'd0);
    check(rd1 == 64'h0000_0000_0000_0082, "R6 state two-thread", rd1, 64'h82);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule